// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer execution unit of a small load/store core. Each operation takes two 32-bit operands and a 4-bit operation code. It computes add, subtract, bitwise XOR/OR/AND, shifts, and signed or unsigned multiply and divide in one combinational pass. The outcome is captured in a single output register stage. The block also holds the architectural HI/LO register pair that multiply and divide write in place of the normal destination.

Operations enter on a valid/ready handshake. An operation is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty, or when the occupant is leaving in the same cycle (`out_ready` high). The result appears with `out_valid` one cycle after acceptance. It stays frozen while `out_ready` is low, so back-pressure from the consumer stalls the producer without dropping work.

Each result carries a status word for the core's flag register: carry in bit 0, overflow in bit 1, zero in bit 2 and sign in bit 3. It also carries an exception request vector whose bit index is the exception vector number. Bit 0 flags a zero divisor. Bit 2 flags arithmetic overflow.

Top module: `int_alu_core`

## Requirements
- R1: An operation is accepted when `in_valid` and `in_ready` are high on a rising edge. `in_ready` equals `!out_valid || out_ready`. The result is presented with `out_valid` in the following cycle. While `out_valid` is high and `out_ready` is low, every output field holds steady.
- R2: Operation codes are 0 add, 1 subtract, 2 XOR, 3 OR and 4 AND. Their 32-bit result is on `out_result` with `out_wr` = 1, and the result wraps modulo 2^32.
- R3: Codes 5, 6 and 7 are logical left shift, logical right shift and arithmetic right shift. Each shifts operand A by the low 5 bits of operand B only, and gives `out_wr` = 1.
- R4: The status word places carry at bit 0, overflow at bit 1, zero at bit 2 and sign at bit 3. Bits 31..4 are always zero. For operations that write `out_result`, zero is set exactly when the result is 0 and sign equals result bit 31.
- R5: For add, carry is the unsigned carry out. For subtract, carry is 1 exactly when A >= B unsigned (no borrow). For both, overflow is signed two's-complement overflow. Logic and shift operations clear carry and overflow.
- R6: Codes 8 (signed) and 9 (unsigned) multiply. HI receives bits 63..32 of the 64-bit product and LO receives bits 31..0. The result is given with `out_wr` = 0 and `out_result` = 0. Zero is set when the whole product is 0, sign is product bit 63, and carry and overflow are 0.
- R7: Codes 10 (signed) and 11 (unsigned) divide with a nonzero divisor. LO receives the quotient and HI the remainder. Signed division truncates toward zero and the remainder takes the dividend's sign. The result is given with `out_wr` = 0 and `out_result` = 0, and zero and sign describe the quotient.
- R8: A divide (code 10 or 11) with B = 0 raises exception bit 0. It leaves HI and LO unchanged, and gives `out_wr` = 0, `out_result` = 0 and an all-zero status word.
- R9: Exception bit 2 and the overflow flag are raised on signed add/subtract overflow. They are also raised on signed 0x80000000 / 0xFFFFFFFF, which yields quotient 0x80000000 and remainder 0. Exception bits other than 0 and 2 are always zero.
- R10: Codes 12 to 15 are reserved. They give `out_wr` = 0, `out_result` = 0, a zero status word and no exception, and they leave HI/LO unchanged.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, and HI and LO are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B (shift amount in low 5 bits) |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Destination value |
| out_wr | output | 1 | Destination value is to be written |
| out_flags | output | 32 | Status word: C, V, Z, S in bits 0..3 |
| out_exc | output | 8 | Exception requests indexed by vector number |
| hi | output | 32 | HI register (product high / remainder) |
| lo | output | 32 | LO register (product low / quotient) |

## Verification
The HI/LO pair is the only state that outlives one operation. If it is corrupted by a zero-divisor or reserved operation, nothing shows until the next result is presented, one cycle later, on the `hi` and `lo` ports. The bench's model therefore carries its own HI/LO copy across the whole sequence, so a stale or spurious update is caught at the first presented result after it. A broken handshake shows immediately: a result that is missing in the cycle after acceptance, or one that changes while stalled, is a mismatch in that same cycle. Wrong flag or exception bits show on the very result that caused them.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_XOR  = 4'd2,
    OP_OR   = 4'd3,
    OP_AND  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_MUL  = 4'd8,
    OP_MULU = 4'd9,
    OP_DIV  = 4'd10,
    OP_DIVU = 4'd11
  } alu_op_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_S = 3;

  localparam int EXC_DIV0 = 0;
  localparam int EXC_OVF  = 2;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;

  always_comb begin
    b_eff = sub ? ~b : b;
    // subtract as a + ~b + 1: carry out then means no borrow
    ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = ext[W-1:0];
    carry = ext[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_logsh.sv
module alu_logsh #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import alu_pkg::*;

  logic [SHW-1:0] shamt;

  always_comb begin
    shamt = b[SHW-1:0];
    unique case (op)
      OP_XOR:  y = a ^ b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_SLL:  y = a << shamt;
      OP_SRL:  y = a >> shamt;
      OP_SRA:  y = W'($signed(a) >>> shamt);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  input  logic         is_div,
  output logic [W-1:0] hi_v,
  output logic [W-1:0] lo_v,
  output logic         div0,
  output logic         dovf
);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [2*W-1:0] ext_a, ext_b, prod;
  logic [W-1:0]   mag_a, mag_b, divisor, uq, ur, q, r;
  logic           neg_a, neg_b;

  always_comb begin
    // one shared multiplier: the operand extension picks signedness
    ext_a = {{W{is_signed & a[W-1]}}, a};
    ext_b = {{W{is_signed & b[W-1]}}, b};
    prod  = ext_a * ext_b;

    neg_a   = is_signed & a[W-1];
    neg_b   = is_signed & b[W-1];
    mag_a   = neg_a ? -a : a;
    mag_b   = neg_b ? -b : b;
    div0    = (b == '0);
    divisor = div0 ? {{(W-1){1'b0}}, 1'b1} : mag_b;
    uq      = mag_a / divisor;
    ur      = mag_a % divisor;
    q       = (neg_a ^ neg_b) ? -uq : uq;
    r       = neg_a ? -ur : ur;
    dovf    = is_signed && (a == SMIN) && (b == '1);

    hi_v = is_div ? r : prod[2*W-1:W];
    lo_v = is_div ? q : prod[W-1:0];
  end
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core #(
  parameter int W     = 32,
  parameter int FLAGW = 32,
  parameter int NVEC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic             out_wr,
  output logic [FLAGW-1:0] out_flags,
  output logic [NVEC-1:0]  out_exc,
  output logic [W-1:0]     hi,
  output logic [W-1:0]     lo
);
  import alu_pkg::*;

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  logic [W-1:0] as_sum, ls_y, md_hi, md_lo;
  logic         as_c, as_v, md_div0, md_dovf;
  logic         md_signed, md_isdiv;

  assign md_signed = (op == OP_MUL) || (op == OP_DIV);
  assign md_isdiv  = (op == OP_DIV) || (op == OP_DIVU);

  alu_addsub #(.W(W)) u_addsub (
    .a(in_a), .b(in_b), .sub(op == OP_SUB),
    .sum(as_sum), .carry(as_c), .ovf(as_v)
  );

  alu_logsh #(.W(W)) u_logsh (
    .op(in_op), .a(in_a), .b(in_b), .y(ls_y)
  );

  alu_muldiv #(.W(W)) u_muldiv (
    .a(in_a), .b(in_b), .is_signed(md_signed), .is_div(md_isdiv),
    .hi_v(md_hi), .lo_v(md_lo), .div0(md_div0), .dovf(md_dovf)
  );

  logic [W-1:0]     nx_res;
  logic             nx_wr, nx_hilo_we, fc, fv, fz, fs;
  logic [FLAGW-1:0] nx_flags;
  logic [NVEC-1:0]  nx_exc;

  always_comb begin
    nx_res     = '0;
    nx_wr      = 1'b0;
    nx_hilo_we = 1'b0;
    nx_exc     = '0;
    fc = 1'b0; fv = 1'b0; fz = 1'b0; fs = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        nx_res = as_sum;
        nx_wr  = 1'b1;
        fc     = as_c;
        fv     = as_v;
        fz     = (as_sum == '0);
        fs     = as_sum[W-1];
        nx_exc[EXC_OVF] = as_v;
      end
      OP_XOR, OP_OR, OP_AND, OP_SLL, OP_SRL, OP_SRA: begin
        nx_res = ls_y;
        nx_wr  = 1'b1;
        fz     = (ls_y == '0);
        fs     = ls_y[W-1];
      end
      OP_MUL, OP_MULU: begin
        nx_hilo_we = 1'b1;
        fz         = ({md_hi, md_lo} == '0);
        fs         = md_hi[W-1];
      end
      OP_DIV, OP_DIVU: begin
        if (md_div0) begin
          nx_exc[EXC_DIV0] = 1'b1;
        end else begin
          nx_hilo_we = 1'b1;
          fz         = (md_lo == '0);
          fs         = md_lo[W-1];
          fv         = md_dovf;
          nx_exc[EXC_OVF] = md_dovf;
        end
      end
      default: ;
    endcase
    nx_flags         = '0;
    nx_flags[FLAG_C] = fc;
    nx_flags[FLAG_V] = fv;
    nx_flags[FLAG_Z] = fz;
    nx_flags[FLAG_S] = fs;
  end

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
      out_flags  <= '0;
      out_exc    <= '0;
      hi         <= '0;
      lo         <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= nx_res;
      out_wr     <= nx_wr;
      out_flags  <= nx_flags;
      out_exc    <= nx_exc;
      if (nx_hilo_we) begin
        hi <= md_hi;
        lo <= md_lo;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int W     = 32,
  parameter int FLAGW = 32,
  parameter int NVEC  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [W-1:0]     in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result,
  input logic             out_wr,
  input logic [FLAGW-1:0] out_flags,
  input logic [NVEC-1:0]  out_exc,
  input logic [W-1:0]     hi,
  input logic [W-1:0]     lo
);
  import alu_pkg::*;

  logic [NVEC-1:0] exc_allowed;
  always_comb begin
    exc_allowed           = '0;
    exc_allowed[EXC_DIV0] = 1'b1;
    exc_allowed[EXC_OVF]  = 1'b1;
  end

  // R1: an empty output slot always admits an operation
  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1: a stalled result holds every field
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_exc) && $stable(out_wr));

  // R4: upper status bits are zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[FLAGW-1:4] == '0);

  // R4: Z and S describe a written result
  a_r4_zs_track: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr |-> (out_flags[FLAG_Z] == (out_result == '0)) &&
      (out_flags[FLAG_S] == out_result[W-1]));

  // R6: multiply does not write the destination
  a_r6_mul_nowr: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == OP_MUL || in_op == OP_MULU)
      |=> out_valid && !out_wr && out_result == '0);

  // R8: a zero divisor leaves HI/LO untouched
  a_r8_div0_keeps_hilo: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == OP_DIV || in_op == OP_DIVU) && in_b == '0
      |=> $stable(hi) && $stable(lo) && out_exc[EXC_DIV0] && out_flags == '0);

  // R9: only vectors 0 and 2 are ever requested, never both
  a_r9_exc_bits: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_exc & ~exc_allowed) == '0) &&
      !(out_exc[EXC_DIV0] && out_exc[EXC_OVF]));

  // R10: reserved codes leave HI/LO untouched
  a_r10_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op >= 4'd12
      |=> $stable(hi) && $stable(lo) && !out_wr && out_exc == '0);
endmodule

bind int_alu_core alu_checker #(.W(W), .FLAGW(FLAGW), .NVEC(NVEC)) u_alu_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_wr(out_wr), .out_flags(out_flags),
  .out_exc(out_exc), .hi(hi), .lo(lo)
);

// File: tb/tb_int_alu_core.sv
module tb_int_alu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, out_wr;
  logic [3:0]  in_op;
  logic [31:0] in_a, in_b, out_result, out_flags, hi, lo;
  logic [7:0]  out_exc;

  always #10 clk = ~clk;

  int_alu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wr(out_wr),
    .out_flags(out_flags), .out_exc(out_exc), .hi(hi), .lo(lo)
  );

  typedef struct {
    logic [3:0]  op;
    logic [31:0] b;
    logic [31:0] res;
    logic        wr;
    logic [31:0] flags;
    logic [7:0]  exc;
    logic [31:0] hi;
    logic [31:0] lo;
  } exp_t;

  exp_t        q[$];
  logic [31:0] m_hi = '0, m_lo = '0;
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;
  bit          bp_on = 0;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -SMAX - 1;

  function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    exp_t e;
    longint sa, sb, t, rm;
    longint unsigned ua, ub;
    logic [63:0] p;
    logic c, v, z, s;
    sa = $signed(a); sb = $signed(b); ua = a; ub = b;
    c = 0; v = 0; z = 0; s = 0;
    e.op = op; e.b = b; e.res = '0; e.wr = 0; e.exc = '0;
    case (op)
      4'd0: begin e.res = a + b; e.wr = 1; c = (ua + ub) > 64'hFFFFFFFF;
                  t = sa + sb; v = (t > SMAX) || (t < SMIN); end
      4'd1: begin e.res = a - b; e.wr = 1; c = (a >= b);
                  t = sa - sb; v = (t > SMAX) || (t < SMIN); end
      4'd2: begin e.res = a ^ b; e.wr = 1; end
      4'd3: begin e.res = a | b; e.wr = 1; end
      4'd4: begin e.res = a & b; e.wr = 1; end
      4'd5: begin e.res = a << b[4:0]; e.wr = 1; end
      4'd6: begin e.res = a >> b[4:0]; e.wr = 1; end
      4'd7: begin e.res = 32'($signed(a) >>> b[4:0]); e.wr = 1; end
      4'd8: begin p = 64'(sa * sb); m_hi = p[63:32]; m_lo = p[31:0];
                  z = (p == 0); s = p[63]; end
      4'd9: begin p = 64'(ua * ub); m_hi = p[63:32]; m_lo = p[31:0];
                  z = (p == 0); s = p[63]; end
      4'd10: if (b == 0) e.exc[0] = 1;
             else begin t = sa / sb; rm = sa % sb; m_lo = t[31:0]; m_hi = rm[31:0];
                  v = (t > SMAX); z = (m_lo == 0); s = m_lo[31]; end
      4'd11: if (b == 0) e.exc[0] = 1;
             else begin m_lo = 32'(ua / ub); m_hi = 32'(ua % ub);
                  z = (m_lo == 0); s = m_lo[31]; end
      default: ;
    endcase
    if (e.wr) begin z = (e.res == 0); s = e.res[31]; end
    e.exc[2] = v;
    e.flags = {28'd0, s, z, v, c};
    e.hi = m_hi; e.lo = m_lo;
    return e;
  endfunction

  function automatic string op_tag(exp_t e);
    if (e.op <= 4'd4) return "R2";
    if (e.op <= 4'd7) return "R3";
    if (e.op <= 4'd9) return "R6";
    if (e.op <= 4'd11) return (e.b == 0) ? "R8" : "R7";
    return "R10";
  endfunction

  task automatic chk32(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // compare the presented result against the model, every cycle
  task automatic check_out();
    exp_t e;
    if (out_valid) begin
      if (q.size() == 0) begin
        chk32("R1", "spurious out_valid", 32'(out_valid), 32'd0);
        return;
      end
      e = q[0];
      chk32(op_tag(e), "result", out_result, e.res);
      chk32(op_tag(e), "wr", 32'(out_wr), 32'(e.wr));
      chk32(e.op <= 4'd1 ? "R5" : "R4", "flags", out_flags, e.flags);
      chk32("R9", "exc", 32'(out_exc), 32'(e.exc));
      chk32(op_tag(e), "hi", hi, e.hi);
      chk32(op_tag(e), "lo", lo, e.lo);
      if (out_ready) void'(q.pop_front());
    end else begin
      chk32("R1", "out_valid missing", 32'(out_valid), 32'(q.size() != 0));
    end
    chk32("R1", "in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
  endtask

  task automatic cycle(input bit v, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, output bit acc);
    @(negedge clk);
    in_valid = v; in_op = op; in_a = a; in_b = b;
    out_ready = bp_on ? ($urandom_range(3) != 0) : 1'b1;
    #1;
    check_out();
    acc = in_valid && in_ready;
    if (acc) q.push_back(model(op, a, b));
  endtask

  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    bit acc;
    do cycle(1'b1, op, a, b, acc); while (!acc);
  endtask

  logic [31:0] corners [10] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
    32'hFFFFFFFF, 32'h12345678, 32'hFFFFFFFE, 32'd5, 32'd33, 32'hDEADBEEF};

  initial begin
    bit acc;
    rst_n = 0; in_valid = 0; in_op = '0; in_a = '0; in_b = '0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R11: reset state
    chk32("R11", "out_valid after reset", 32'(out_valid), 32'd0);
    chk32("R11", "in_ready after reset", 32'(in_ready), 32'd1);
    chk32("R11", "hi after reset", hi, 32'd0);
    chk32("R11", "lo after reset", lo, 32'd0);

    // seed HI/LO, then a zero divisor and reserved codes must keep them (R8, R10)
    send(4'd9, 32'h00010001, 32'h00010001);
    send(4'd10, 32'd7, 32'd0);
    send(4'd13, 32'd7, 32'd3);
    // signed overflow cases (R9) and subtract borrow (R5)
    send(4'd10, 32'h80000000, 32'hFFFFFFFF);
    send(4'd0, 32'h7FFFFFFF, 32'd1);
    send(4'd1, 32'd3, 32'd5);
    send(4'd10, 32'hFFFFFFF9, 32'd2);

    // corner sweep of every code, with back-pressure on half of it
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++) begin
          bp_on = (op % 2 == 1);
          send(4'(op), corners[i], corners[j]);
        end

    // random traffic with idle gaps and stalls
    bp_on = 1;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(9) == 0) cycle(1'b0, 4'd0, 32'd0, 32'd0, acc);
      else send(4'($urandom_range(15)), $urandom,
                ($urandom_range(7) == 0) ? 32'd0 : $urandom);
    end

    bp_on = 0;
    repeat (3) cycle(1'b0, 4'd0, 32'd0, 32'd0, acc);
    chk32("R1", "queue drained", 32'(q.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule